// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit keeps the eight-bit status byte of a serial nonvolatile memory and decides, in every cycle, whether a memory write and a status write may proceed. A command engine sends it single-cycle strobes: enable writes, disable writes, status-write completion with the received data byte, and memory-write completion. It also reads the write-protect pin level and the address that the command engine wants to write.

The unit returns the status byte to shift out during a status read. It also returns two permit flags that the command engine samples before it commits a write. The permit flags are combinational functions of the present state, the pin and the address. Any change a strobe causes is visible on the status byte one clock later.

Two resets are provided. An initial reset models the factory state of the persistent bits and clears the whole byte. A power-on reset clears only the volatile enable latch, so protection settings survive it.

Top module: `sreg_guard`

## Requirements
- R1: The status byte carries the lock bit at position 7, three spare bits at 6:4, the two-bit block code at 3:2, the enable latch at 1, and bit 0 reads as 0 at all times.
- R2: The enable latch is set one clock after an enable strobe. It is cleared one clock after a disable strobe, a status-write completion or a memory-write completion. When an enable strobe coincides with any clearing strobe, the latch ends cleared.
- R3: While the power-on reset (rst_n low) is sampled, the enable latch clears and bits 7:2 keep their value. While the initial reset (init_n low) is sampled, all eight bits become 0.
- R4: A permitted status write loads data bits 7:2 into status bits 7:2 on the next clock. Data bits 1:0 are ignored.
- R5: A status write that is not permitted leaves bits 7:2 unchanged, and it still clears the enable latch.
- R6: Block code 00 protects no address. Code 01 protects 0x3000-0x3FFF, code 10 protects 0x2000-0x3FFF, and code 11 protects the full 0x0000-0x3FFF range.
- R7: mem_wr_ok_o is 1 exactly when the enable latch is 1 and the address on wr_addr_i is outside the protected range.
- R8: stat_wr_ok_o is 1 exactly when the enable latch is 1 and either the lock bit is 0 or wp_i is high.
- R9: Both permits come from the state held before the edge at which a strobe acts. A status write that changes the lock bit or the block code does not affect its own permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset, clears the enable latch only |
| init_n | input | 1 | Synchronous active-low initial reset, clears the whole status byte |
| wren_i | input | 1 | Enable-writes strobe |
| wrdi_i | input | 1 | Disable-writes strobe |
| stat_wr_i | input | 1 | Status-write completion strobe |
| stat_data_i | input | 8 | Data byte received with the status write |
| mem_wr_i | input | 1 | Memory-write completion strobe |
| wp_i | input | 1 | Write-protect pin level, high means not asserted |
| wr_addr_i | input | 14 | Address that the command engine wants to write |
| status_o | output | 8 | Status byte for the read path |
| mem_wr_ok_o | output | 1 | Memory write allowed at wr_addr_i |
| stat_wr_ok_o | output | 1 | Status write allowed |

## Verification
A status-write completion changes bits 7:2 and clears the enable latch at the same edge. An enable strobe can also meet a memory-write completion or a disable strobe in the same cycle. The vector table drives each of these pairs together: a permitted and a blocked status write, an enable with a disable, and an enable with a memory write. At the edge the bench checks that the clear wins and that only a permitted write moves the upper bits. The permit flags are sampled before the edge, so they are judged against the state that existed before the write changed the lock bit or the block code.

// File: rtl/sreg_pkg.sv
// Shared definitions for the status register unit.
// Assumes a two-bit block code selecting top fractions of the array.
package sreg_pkg;

    localparam int STAT_W  = 8;   // status byte width
    localparam int NV_LO   = 2;   // lowest persistent bit
    localparam int NV_W    = STAT_W - NV_LO;
    localparam int LOCK_B  = 7;   // lock bit position
    localparam int WEL_B   = 1;   // enable latch position

    typedef enum logic [1:0] {
        BLK_NONE    = 2'b00,
        BLK_QUARTER = 2'b01,
        BLK_HALF    = 2'b10,
        BLK_ALL     = 2'b11
    } blk_code_e;

endpackage

// File: rtl/sreg_wel.sv
// Volatile write-enable latch.
// Assumes strobes are single-cycle; any clear beats a set.
module sreg_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic init_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    // Latch update: resets, then clear priority, then set.
    always_ff @(posedge clk) begin
        if (!rst_n || !init_n)
            wel_o <= 1'b0;
        else if (clr_i)
            wel_o <= 1'b0;
        else if (set_i)
            wel_o <= 1'b1;
    end
endmodule

// File: rtl/sreg_nv.sv
// Persistent bits of the status byte (lock, spares, block code).
// Assumes only the initial reset clears them; power-on reset does not.
module sreg_nv #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         init_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] q_o
);
    // Register the persistent field on a permitted load.
    always_ff @(posedge clk) begin
        if (!init_n)
            q_o <= '0;
        else if (load_i)
            q_o <= din_i;
    end
endmodule

// File: rtl/sreg_prot.sv
// Protection decode: range check on the address and the two permits.
// Assumes a block code selecting a power-of-two top fraction of the array.
module sreg_prot #(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        blk_i,
    input  logic              wel_i,
    input  logic              lock_i,
    input  logic              wp_i,
    output logic              mem_ok_o,
    output logic              stat_ok_o
);
    import sreg_pkg::*;

    logic in_range;

    // Decide whether the address lies inside the guarded top fraction.
    always_comb begin
        unique case (blk_code_e'(blk_i))
            BLK_NONE:    in_range = 1'b0;
            BLK_QUARTER: in_range = &addr_i[ADDR_W-1 -: 2];
            BLK_HALF:    in_range = addr_i[ADDR_W-1];
            default:     in_range = 1'b1;
        endcase
    end

    // Combine enable latch, range and pin-gated lock into permits.
    always_comb begin
        mem_ok_o  = wel_i && !in_range;
        stat_ok_o = wel_i && (!lock_i || wp_i);
    end
endmodule

// File: rtl/sreg_guard.sv
// Top of the status register and write-protect unit.
// Assumes single-cycle strobes from a command engine; permits reflect
// the state before the edge at which any strobe takes effect.
module sreg_guard #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              stat_wr_i,
    input  logic [7:0]        stat_data_i,
    input  logic              mem_wr_i,
    input  logic              wp_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic [7:0]        status_o,
    output logic              mem_wr_ok_o,
    output logic              stat_wr_ok_o
);
    import sreg_pkg::*;

    logic            wel_q;
    logic [NV_W-1:0] nv_q;
    logic            clr_any;
    logic            nv_load;

    // Any command that ends a write cycle drops the enable latch.
    always_comb begin
        clr_any = wrdi_i || stat_wr_i || mem_wr_i;
        nv_load = stat_wr_i && stat_wr_ok_o;
    end

    sreg_wel u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_n (init_n),
        .set_i  (wren_i),
        .clr_i  (clr_any),
        .wel_o  (wel_q)
    );

    sreg_nv #(.W(NV_W)) u_nv (
        .clk    (clk),
        .init_n (init_n),
        .load_i (nv_load),
        .din_i  (stat_data_i[STAT_W-1:NV_LO]),
        .q_o    (nv_q)
    );

    sreg_prot #(.ADDR_W(ADDR_W)) u_prot (
        .addr_i    (wr_addr_i),
        .blk_i     (nv_q[1:0]),
        .wel_i     (wel_q),
        .lock_i    (nv_q[NV_W-1]),
        .wp_i      (wp_i),
        .mem_ok_o  (mem_wr_ok_o),
        .stat_ok_o (stat_wr_ok_o)
    );

    // Assemble the byte seen by the read path.
    always_comb status_o = {nv_q, wel_q, 1'b0};
endmodule

// File: rtl/sreg_guard_chk.sv
// Checker for sreg_guard, attached by bind.
module sreg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       init_n,
    input logic       wren_i,
    input logic       wrdi_i,
    input logic       stat_wr_i,
    input logic       mem_wr_i,
    input logic       wp_i,
    input logic [7:0] status_o,
    input logic       mem_wr_ok_o,
    input logic       stat_wr_ok_o
);
    a_r1_bit0_zero: assert property (@(posedge clk) disable iff (!init_n)
        status_o[0] == 1'b0);

    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (wren_i && !wrdi_i && !stat_wr_i && !mem_wr_i) |=> status_o[1]);

    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (wrdi_i || stat_wr_i || mem_wr_i) |=> !status_o[1]);

    a_r3_por: assert property (@(posedge clk)
        (!rst_n) |=> !status_o[1]);

    a_r3_init: assert property (@(posedge clk)
        (!init_n) |=> (status_o == 8'h00));

    a_r3_keep: assert property (@(posedge clk)
        (!rst_n && init_n) |=> $stable(status_o[7:2]));

    a_r5_blocked: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        (stat_wr_i && !stat_wr_ok_o) |=> $stable(status_o[7:2]));

    a_r7_mem_needs_wel: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        mem_wr_ok_o |-> status_o[1]);

    a_r8_stat_permit: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
        stat_wr_ok_o |-> (status_o[1] && (!status_o[7] || wp_i)));
endmodule

bind sreg_guard sreg_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_n       (init_n),
    .wren_i       (wren_i),
    .wrdi_i       (wrdi_i),
    .stat_wr_i    (stat_wr_i),
    .mem_wr_i     (mem_wr_i),
    .wp_i         (wp_i),
    .status_o     (status_o),
    .mem_wr_ok_o  (mem_wr_ok_o),
    .stat_wr_ok_o (stat_wr_ok_o)
);

// File: tb/tb_sreg_guard.sv
`timescale 1ns/1ps
module tb_sreg_guard;
    logic        clk = 1'b0;
    logic        rst_n, init_n;
    logic        wren, wrdi, swr, mwr, wp;
    logic [7:0]  sdata;
    logic [13:0] addr;
    logic [7:0]  status;
    logic        mem_ok, st_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sreg_guard dut (
        .clk(clk), .rst_n(rst_n), .init_n(init_n),
        .wren_i(wren), .wrdi_i(wrdi), .stat_wr_i(swr), .stat_data_i(sdata),
        .mem_wr_i(mwr), .wp_i(wp), .wr_addr_i(addr),
        .status_o(status), .mem_wr_ok_o(mem_ok), .stat_wr_ok_o(st_ok)
    );

    // {wren,wrdi,swr,mwr, wp, data, addr, exp_mem_ok, exp_st_ok, exp_status_after}
    localparam int NV = 24;
    localparam logic [36:0] VEC [NV] = '{
        {4'b0000, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'h00}, // R7 R8 latch low
        {4'b1000, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'h02}, // R2 set
        {4'b0000, 1'b0, 8'h00, 14'h3FFF, 1'b1, 1'b1, 8'h02}, // R6 code 00
        {4'b0010, 1'b0, 8'hFF, 14'h0000, 1'b1, 1'b1, 8'hFC}, // R4 R1 write all ones
        {4'b1000, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'hFE},
        {4'b0000, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'hFE}, // R6 code 11, R8 lock+pin low
        {4'b0000, 1'b1, 8'h00, 14'h1234, 1'b0, 1'b1, 8'hFE}, // R8 pin high
        {4'b0010, 1'b0, 8'h05, 14'h0000, 1'b0, 1'b0, 8'hFC}, // R5 blocked write
        {4'b1000, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'hFE},
        {4'b0010, 1'b1, 8'h07, 14'h0000, 1'b0, 1'b1, 8'h04}, // R4 R9 low bits ignored
        {4'b1000, 1'b0, 8'h00, 14'h2FFF, 1'b0, 1'b0, 8'h06},
        {4'b0000, 1'b0, 8'h00, 14'h2FFF, 1'b1, 1'b1, 8'h06}, // R6 code 01 edge below
        {4'b0000, 1'b0, 8'h00, 14'h3000, 1'b0, 1'b1, 8'h06}, // R6 code 01 edge
        {4'b0001, 1'b0, 8'h00, 14'h3000, 1'b0, 1'b1, 8'h04}, // R2 memory write clears
        {4'b1100, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'h04}, // R2 set with disable
        {4'b1000, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'h06},
        {4'b0010, 1'b0, 8'h08, 14'h1FFF, 1'b1, 1'b1, 8'h08}, // R9 own permit uses old code
        {4'b1000, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'h0A},
        {4'b0000, 1'b0, 8'h00, 14'h1FFF, 1'b1, 1'b1, 8'h0A}, // R6 code 10 below
        {4'b0000, 1'b0, 8'h00, 14'h2000, 1'b0, 1'b1, 8'h0A}, // R6 code 10 edge
        {4'b0001, 1'b0, 8'h00, 14'h1FFF, 1'b1, 1'b1, 8'h08}, // R7
        {4'b1001, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'h08}, // R2 set with memory write
        {4'b1000, 1'b0, 8'h00, 14'h0000, 1'b0, 1'b0, 8'h0A},
        {4'b0100, 1'b0, 8'h00, 14'h0000, 1'b1, 1'b1, 8'h08}  // R2 disable
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {wren, wrdi, swr, mwr} = 4'b0000;
        sdata = 8'h00;
    endtask

    initial begin
        rst_n = 1'b0; init_n = 1'b0; wp = 1'b0; addr = '0;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1; init_n = 1'b1;
        @(negedge clk);
        check("R3 initial state", status, 8'h00);

        for (int i = 0; i < NV; i++) begin
            {wren, wrdi, swr, mwr, wp, sdata, addr} = VEC[i][36:10];
            #1;
            check($sformatf("R7 vec %0d mem_wr_ok", i), mem_ok, VEC[i][9]);
            check($sformatf("R8 vec %0d stat_wr_ok", i), st_ok, VEC[i][8]);
            @(negedge clk);
            check($sformatf("R2/R4 vec %0d status", i), status, VEC[i][7:0]);
        end
        idle();

        // R3: power-on reset keeps persistent bits, drops the latch
        wren = 1'b1; @(negedge clk); idle();
        check("R2 latch before reset", status, 8'h0A);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R3 power-on keeps bits 7:2", status, 8'h08);

        // R3: initial reset clears all
        wren = 1'b1; @(negedge clk); idle();
        init_n = 1'b0; @(negedge clk); init_n = 1'b1;
        check("R3 initial reset clears byte", status, 8'h00);

        // R1: bit 0 stays 0 after writing all ones with the latch set
        wren = 1'b1; @(negedge clk); idle();
        wren = 1'b1; swr = 1'b1; sdata = 8'hFF; @(negedge clk); idle();
        check("R1 bit 0 low", status[0], 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule